// File: doc/BRIEF.md
# Aliased Sub-Word Register File

This block holds eight 32-bit general registers and lets each access pick a register and a view of it: the whole word, its low 16 bits, its low byte or its second byte. Narrow writes merge into the stored word, so a byte write changes one byte and keeps the other three. Narrow reads return the chosen slice zero-extended to the full width, so downstream logic always sees one data width.

Registers 0 to 3 are data registers with all four views. Registers 4 to 7 are pointer and index registers that offer only the word and low-half views. A byte view requested on one of them is flagged as illegal on that port. For a read, the data is forced to zero. For a write, nothing is stored. There are two combinational read ports and one write port that takes effect at the rising clock edge.

Top module: `aliased_regfile`

## Requirements
- R1: There are eight registers, indexed 0 to 7. Indices 0 to 3 accept every view, and indices 4 to 7 accept only the word and half views.
- R2: View code 00 (word) writes all 32 bits from `wr_data` and reads back all 32 bits.
- R3: View code 01 (half) writes bits 15:0 from `wr_data[15:0]` and keeps bits 31:16. A half read returns bits 15:0 in bits 15:0 of the output.
- R4: View code 10 (low byte) writes bits 7:0 from `wr_data[7:0]`. View code 11 (second byte) writes bits 15:8 from `wr_data[7:0]`. Both keep every other bit.
- R5: Every read output bit above the selected slice is zero. A second-byte read returns bits 15:8 in output bits 7:0.
- R6: A byte view (code 10 or 11) on index 4 to 7 drives the port's illegal flag high in the same cycle. An illegal read returns zero. An illegal write leaves every register unchanged.
- R7: The two read ports are independent and combinational: each shows its own register and view in the cycle it is addressed.
- R8: When a register is read and written in the same cycle, the read shows the old value before the edge and the new value after it.
- R9: An active-low reset clears every register to zero, at once and without waiting for a clock edge.
- R10: With `wr_en` low, no register changes, whatever the other write inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| rd0_idx | input | 3 | Register index, read port 0 |
| rd0_sel | input | 2 | View code, read port 0 |
| rd0_data | output | 32 | Zero-extended read data, port 0 |
| rd0_illegal | output | 1 | Byte view requested on a register without byte views, port 0 |
| rd1_idx | input | 3 | Register index, read port 1 |
| rd1_sel | input | 2 | View code, read port 1 |
| rd1_data | output | 32 | Zero-extended read data, port 1 |
| rd1_illegal | output | 1 | Illegal view flag, port 1 |
| wr_en | input | 1 | Write request |
| wr_idx | input | 3 | Register index for the write |
| wr_sel | input | 2 | View code for the write |
| wr_data | input | 32 | Write data; narrow views take it from the low bits |
| wr_illegal | output | 1 | Illegal view flag for the write port; the write is dropped |

## Verification
The bench uses the default parameters: eight registers, four of them with byte views, and 32-bit words. With these values the bench reaches both sides of the byte-view boundary (index 3 against index 4), all four view codes on data registers, and the two legal views on pointer registers. A 16-bit half and two distinct byte lanes leave upper bits that a merge must keep, so a faulty merge shows up as a wrong upper half or a wrong neighbouring byte.

// File: rtl/arf_pkg.sv
package arf_pkg;

  typedef enum logic [1:0] {
    VIEW_WORD = 2'b00,
    VIEW_HALF = 2'b01,
    VIEW_LOB  = 2'b10,
    VIEW_HIB  = 2'b11
  } view_e;

  localparam int unsigned LANE_W = 8;

  function automatic logic is_byte_view(view_e v);
    return (v == VIEW_LOB) || (v == VIEW_HIB);
  endfunction

endpackage

// File: rtl/arf_view_decode.sv
module arf_view_decode
  import arf_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 8,
  parameter int unsigned BYTE_REGS = 4,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned IDX_W    = $clog2(NUM_REGS),
  localparam int unsigned LANES    = DATA_W / LANE_W
) (
  input  logic [IDX_W-1:0] idx,
  input  view_e            view,
  output logic             illegal,
  output logic [LANES-1:0] lane_en
);

  localparam int unsigned HALF_LANES = LANES / 2;

  always_comb begin
    illegal = is_byte_view(view) && (32'(idx) >= BYTE_REGS);
  end

  always_comb begin
    lane_en = '0;
    unique case (view)
      VIEW_WORD: lane_en = '1;
      VIEW_HALF: begin
        for (int l = 0; l < HALF_LANES; l++) lane_en[l] = 1'b1;
      end
      VIEW_LOB:  lane_en[0] = 1'b1;
      VIEW_HIB:  lane_en[1] = 1'b1;
      default:   lane_en = '0;
    endcase
    if (illegal) lane_en = '0;
  end

endmodule

// File: rtl/arf_store.sv
module arf_store
  import arf_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS),
  localparam int unsigned LANES   = DATA_W / LANE_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [LANES-1:0]                 lane_en,
  input  logic [DATA_W-1:0]                wdata,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q
);

  logic [NUM_REGS-1:0][LANES-1:0] lane_we;

  always_comb begin
    for (int r = 0; r < NUM_REGS; r++) begin
      for (int l = 0; l < LANES; l++) begin
        lane_we[r][l] = wr_en && (wr_idx == IDX_W'(r)) && lane_en[l];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else begin
      for (int r = 0; r < NUM_REGS; r++) begin
        for (int l = 0; l < LANES; l++) begin
          if (lane_we[r][l]) begin
            regs_q[r][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
          end
        end
      end
    end
  end

endmodule

// File: rtl/arf_read_port.sv
module arf_read_port
  import arf_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS),
  localparam int unsigned LANES   = DATA_W / LANE_W
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
  input  logic [IDX_W-1:0]                idx,
  input  logic [LANES-1:0]                lane_en,
  input  logic                            shift_down,
  output logic [DATA_W-1:0]               data
);

  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] masked;

  always_comb begin
    word = regs[idx];
    for (int l = 0; l < LANES; l++) begin
      masked[l*LANE_W +: LANE_W] = lane_en[l] ? word[l*LANE_W +: LANE_W] : '0;
    end
    data = shift_down ? (masked >> LANE_W) : masked;
  end

endmodule

// File: rtl/aliased_regfile.sv
module aliased_regfile
  import arf_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 8,
  parameter int unsigned BYTE_REGS = 4,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd0_idx,
  input  logic [1:0]        rd0_sel,
  output logic [DATA_W-1:0] rd0_data,
  output logic              rd0_illegal,
  input  logic [IDX_W-1:0]  rd1_idx,
  input  logic [1:0]        rd1_sel,
  output logic [DATA_W-1:0] rd1_data,
  output logic              rd1_illegal,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_illegal
);

  localparam int unsigned LANES  = DATA_W / LANE_W;
  localparam int unsigned NPORTS = 3;
  localparam int unsigned NREAD  = 2;

  logic [NPORTS-1:0][IDX_W-1:0] p_idx;
  logic [NPORTS-1:0][1:0]       p_sel;
  logic [NPORTS-1:0]            p_illegal;
  logic [NPORTS-1:0][LANES-1:0] p_lane;
  logic [NREAD-1:0][DATA_W-1:0] p_rdata;
  logic [DATA_W-1:0]            wr_aligned;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

  assign p_idx = {wr_idx, rd1_idx, rd0_idx};
  assign p_sel = {wr_sel, rd1_sel, rd0_sel};

  for (genvar g = 0; g < NPORTS; g++) begin : g_dec
    arf_view_decode #(
      .NUM_REGS (NUM_REGS),
      .BYTE_REGS(BYTE_REGS),
      .DATA_W   (DATA_W)
    ) u_dec (
      .idx    (p_idx[g]),
      .view   (view_e'(p_sel[g])),
      .illegal(p_illegal[g]),
      .lane_en(p_lane[g])
    );
  end

  for (genvar g = 0; g < NREAD; g++) begin : g_rd
    arf_read_port #(
      .NUM_REGS(NUM_REGS),
      .DATA_W  (DATA_W)
    ) u_rd (
      .regs      (regs_q),
      .idx       (p_idx[g]),
      .lane_en   (p_lane[g]),
      .shift_down(view_e'(p_sel[g]) == VIEW_HIB),
      .data      (p_rdata[g])
    );
  end

  always_comb begin
    wr_aligned = (view_e'(wr_sel) == VIEW_HIB) ? (wr_data << LANE_W) : wr_data;
  end

  arf_store #(
    .NUM_REGS(NUM_REGS),
    .DATA_W  (DATA_W)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .lane_en(p_lane[2]),
    .wdata  (wr_aligned),
    .regs_q (regs_q)
  );

  assign rd0_data    = p_rdata[0];
  assign rd1_data    = p_rdata[1];
  assign rd0_illegal = p_illegal[0];
  assign rd1_illegal = p_illegal[1];
  assign wr_illegal  = p_illegal[2];

endmodule

// File: rtl/aliased_regfile_chk.sv
module aliased_regfile_chk #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [1:0]                      rd0_sel,
  input logic [DATA_W-1:0]               rd0_data,
  input logic [DATA_W-1:0]               rd1_data,
  input logic                            rd1_illegal,
  input logic                            wr_en,
  input logic [IDX_W-1:0]                wr_idx,
  input logic [1:0]                      wr_sel,
  input logic [DATA_W-1:0]               wr_data,
  input logic                            wr_illegal,
  input logic [NUM_REGS-1:0][DATA_W-1:0] regs_q
);

  logic                            prev_v;
  logic                            prev_we;
  logic                            prev_ill;
  logic [IDX_W-1:0]                prev_idx;
  logic [1:0]                      prev_sel;
  logic [DATA_W-1:0]               prev_data;
  logic [NUM_REGS-1:0][DATA_W-1:0] prev_regs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_v    <= 1'b0;
      prev_we   <= 1'b0;
      prev_ill  <= 1'b0;
      prev_idx  <= '0;
      prev_sel  <= '0;
      prev_data <= '0;
      prev_regs <= '0;
    end else begin
      prev_v    <= 1'b1;
      prev_we   <= wr_en;
      prev_ill  <= wr_illegal;
      prev_idx  <= wr_idx;
      prev_sel  <= wr_sel;
      prev_data <= wr_data;
      prev_regs <= regs_q;
    end
  end

  p_word_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    prev_v && prev_we && prev_sel == 2'b00 |-> regs_q[prev_idx] == prev_data);

  p_half_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    prev_v && prev_we && prev_sel == 2'b01 |->
      regs_q[prev_idx] == {prev_regs[prev_idx][DATA_W-1:16], prev_data[15:0]});

  p_hib_merge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    prev_v && prev_we && prev_sel == 2'b11 && !prev_ill |->
      regs_q[prev_idx] == {prev_regs[prev_idx][DATA_W-1:16], prev_data[7:0],
                           prev_regs[prev_idx][7:0]});

  p_zero_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd0_sel[1] |-> rd0_data[DATA_W-1:8] == '0);

  p_illegal_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prev_v && prev_we && prev_ill |-> regs_q == prev_regs);

  p_illegal_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd1_illegal |-> rd1_data == '0);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    prev_v && !prev_we |-> regs_q == prev_regs);

endmodule

bind aliased_regfile aliased_regfile_chk #(
  .NUM_REGS(NUM_REGS),
  .DATA_W  (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd0_sel    (rd0_sel),
  .rd0_data   (rd0_data),
  .rd1_data   (rd1_data),
  .rd1_illegal(rd1_illegal),
  .wr_en      (wr_en),
  .wr_idx     (wr_idx),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .wr_illegal (wr_illegal),
  .regs_q     (regs_q)
);

// File: tb/tb_aliased_regfile.sv
module tb_aliased_regfile;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 13;

  typedef struct packed {
    logic        we;
    logic [2:0]  widx;
    logic [1:0]  wsel;
    logic [31:0] wdata;
    logic [2:0]  ridx;
    logic [1:0]  rsel;
    logic [31:0] exp;
  } vec_t;

  // view codes: 00 word, 01 half, 10 low byte, 11 second byte
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 3'd0, 2'b00, 32'h1122_3344, 3'd0, 2'b00, 32'h1122_3344}, // R2
    '{1'b1, 3'd0, 2'b01, 32'hAAAA_5566, 3'd0, 2'b00, 32'h1122_5566}, // R3
    '{1'b1, 3'd0, 2'b10, 32'h0000_00F0, 3'd0, 2'b00, 32'h1122_55F0}, // R4
    '{1'b1, 3'd0, 2'b11, 32'h0000_009C, 3'd0, 2'b00, 32'h1122_9CF0}, // R4
    '{1'b0, 3'd0, 2'b00, 32'hFFFF_FFFF, 3'd0, 2'b00, 32'h1122_9CF0}, // R10
    '{1'b1, 3'd1, 2'b00, 32'hDEAD_BEEF, 3'd1, 2'b11, 32'h0000_00BE}, // R5
    '{1'b1, 3'd1, 2'b10, 32'hFFFF_FF12, 3'd1, 2'b01, 32'h0000_BE12}, // R4 R5
    '{1'b1, 3'd5, 2'b00, 32'hCAFE_F00D, 3'd5, 2'b01, 32'h0000_F00D}, // R1 R5
    '{1'b1, 3'd5, 2'b01, 32'h0000_1234, 3'd5, 2'b00, 32'hCAFE_1234}, // R3
    '{1'b1, 3'd3, 2'b11, 32'h0000_00A5, 3'd3, 2'b00, 32'h0000_A500}, // R4
    '{1'b1, 3'd7, 2'b00, 32'h8000_0001, 3'd7, 2'b00, 32'h8000_0001}, // R1
    '{1'b1, 3'd2, 2'b00, 32'h0102_0304, 3'd0, 2'b10, 32'h0000_00F0}, // R5
    '{1'b1, 3'd4, 2'b01, 32'h0000_FFFF, 3'd4, 2'b00, 32'h0000_FFFF}  // R3
  };

  logic        clk;
  logic        rst_n;
  logic [2:0]  rd0_idx, rd1_idx, wr_idx;
  logic [1:0]  rd0_sel, rd1_sel, wr_sel;
  logic [31:0] rd0_data, rd1_data, wr_data;
  logic        rd0_illegal, rd1_illegal, wr_illegal, wr_en;

  int tests;
  int fails;

  aliased_regfile dut (
    .clk(clk), .rst_n(rst_n),
    .rd0_idx(rd0_idx), .rd0_sel(rd0_sel), .rd0_data(rd0_data), .rd0_illegal(rd0_illegal),
    .rd1_idx(rd1_idx), .rd1_sel(rd1_sel), .rd1_data(rd1_data), .rd1_illegal(rd1_illegal),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel), .wr_data(wr_data),
    .wr_illegal(wr_illegal)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive a write at the falling edge, let the rising edge take it, then idle
  task automatic do_write(input logic [2:0] idx, input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_sel = sel; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tests = 0; fails = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_sel = '0; wr_data = '0;
    rd0_idx = '0; rd0_sel = '0; rd1_idx = '0; rd1_sel = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: every register reads zero after reset
    for (int r = 0; r < 8; r++) begin
      rd0_idx = 3'(r); rd0_sel = 2'b00;
      #1 check($sformatf("R9 reset value reg %0d", r), rd0_data, 32'h0);
    end

    // vector table: write, then read back after the edge
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      wr_en = VECS[i].we; wr_idx = VECS[i].widx; wr_sel = VECS[i].wsel; wr_data = VECS[i].wdata;
      rd0_idx = VECS[i].ridx; rd0_sel = VECS[i].rsel;
      @(posedge clk);
      #1 wr_en = 1'b0;
      #1 check($sformatf("vector %0d R2/R3/R4/R5/R10", i), rd0_data, VECS[i].exp);
    end

    // R1: pointer registers keep full words, data registers untouched by them
    @(negedge clk);
    rd0_idx = 3'd7; rd0_sel = 2'b00; rd1_idx = 3'd2; rd1_sel = 2'b00;
    #1 check("R1 reg7 word", rd0_data, 32'h8000_0001);
    check("R7 reg2 word on port 1", rd1_data, 32'h0102_0304);

    // R6: byte views on index 4..7 are flagged; index 3 is not
    @(negedge clk);
    rd1_idx = 3'd6; rd1_sel = 2'b11; wr_idx = 3'd4; wr_sel = 2'b10;
    #1 check("R6 read illegal flag idx6 hib", 32'(rd1_illegal), 32'h1);
    check("R6 write illegal flag idx4 lob", 32'(wr_illegal), 32'h1);
    check("R6 illegal read data zero", rd1_data, 32'h0);
    rd1_idx = 3'd3; rd1_sel = 2'b11;
    #1 check("R6 idx3 hib legal", 32'(rd1_illegal), 32'h0);
    check("R5 idx3 hib read", rd1_data, 32'h0000_00A5);
    rd1_idx = 3'd4; rd1_sel = 2'b01;
    #1 check("R6 idx4 half legal", 32'(rd1_illegal), 32'h0);

    // R6: illegal byte write must not change register 6
    do_write(3'd6, 2'b00, 32'h0000_7777);
    do_write(3'd6, 2'b11, 32'h0000_0055);
    do_write(3'd6, 2'b10, 32'h0000_0066);
    rd0_idx = 3'd6; rd0_sel = 2'b00;
    #1 check("R6 suppressed write reg6", rd0_data, 32'h0000_7777);

    // R8 / R7: same-cycle read and write of register 2
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd2; wr_sel = 2'b00; wr_data = 32'hA0B0_C0D0;
    rd0_idx = 3'd2; rd0_sel = 2'b00; rd1_idx = 3'd2; rd1_sel = 2'b11;
    #1 check("R8 old value before edge", rd0_data, 32'h0102_0304);
    check("R7 port 1 hib before edge", rd1_data, 32'h0000_0003);
    @(posedge clk);
    #1 wr_en = 1'b0;
    #1 check("R8 new value after edge", rd0_data, 32'hA0B0_C0D0);
    check("R7 port 1 hib after edge", rd1_data, 32'h0000_00C0);

    // R9: asynchronous clear with no clock edge
    @(negedge clk);
    rd0_idx = 3'd0; rd0_sel = 2'b00; rd1_idx = 3'd7; rd1_sel = 2'b00;
    #1 rst_n = 1'b0;
    #1 check("R9 async clear reg0", rd0_data, 32'h0);
    check("R9 async clear reg7", rd1_data, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule